// File: doc/BRIEF.md
# Pixel Readout Token Sequencer

This block is the digital control for one section of a linear photodiode array. A start pulse on the serial input enters a chain of 128 token stages that share one clock. While the token sits in a stage, the matching pixel is selected for readout. The select is given both as a one-hot vector and as a binary index with a valid bit. One cycle after a pixel has been read, a reset strobe goes to that pixel's integrator, which starts its next integration period. An output-enable marks the window in which the analog output leaves high impedance.

When the token drops off the last stage, a one-cycle end pulse appears on the serial output. That pulse can drive the serial input of the next section, so several sections form one long contiguous line. The sections can also run side by side from separate start pulses. A start that arrives while a readout is in progress is ignored, and a sticky error flag records it. A synchronous reset returns the section to idle.

Top module: `pix_token_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has no selected pixel, `sel_valid_o`, `out_en_o`, `end_o` and `err_o` low, and no reset strobe active.
- R2: When `start_i` is high at a rising edge and no pixel is selected, pixel 0 is selected after that edge: `sel_valid_o`=1, `sel_idx_o`=0, and `sel_onehot_o` has only bit 0 set.
- R3: The token advances one stage per rising edge. After the k-th edge, counting the capture edge as 1, pixel k-1 is selected, for k from 1 to 128. `sel_onehot_o` has exactly bit `sel_idx_o` set while valid and is all zero otherwise.
- R4: In the cycle after pixel p was selected, `rst_strobe_o` has only bit p set. In a cycle that follows no selection, it is all zero.
- R5: `out_en_o` is high exactly in the cycles where a pixel is selected, and low everywhere else.
- R6: `end_o` is high for exactly one cycle, after the 129th rising edge counting the capture edge as 1. In that cycle no pixel is selected, unless a new start was captured on that same edge (see R8).
- R7: A start that is high at an edge while a pixel is selected leaves the selection sequence unchanged, and sets `err_o`. `err_o` then stays high until reset. With no such start, `err_o` stays low.
- R8: A start captured on the edge that ends the readout (the cycle in which `end_o` is high) is accepted, and pixel 0 is selected after that edge.
- R9: When `end_o` of one section drives `start_i` of a second section, the second section selects its pixel 0 in the cycle right after the first section's end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Serial start token input |
| sel_onehot_o | output | 128 | One-hot select of the pixel being read |
| sel_idx_o | output | 7 | Binary index of the pixel being read |
| sel_valid_o | output | 1 | Index is valid (a pixel is selected) |
| rst_strobe_o | output | 128 | Per-pixel integrator reset strobe |
| out_en_o | output | 1 | Analog output driven (high) or high impedance (low) |
| end_o | output | 1 | End-of-read token, one cycle, chainable |
| err_o | output | 1 | Sticky flag: a start arrived during a readout |

## Verification
A lost or duplicated token shows at once in the select outputs. Two set bits, or an empty vector while the index is valid, appear in the same cycle. The index and the one-hot vector are held in separate state, so any drift between them is visible in the first cycle it happens. A wrong stage length shows up as a misplaced end pulse or strobe 128 cycles after the capture. A wrongly accepted overlapping start shows as a jump back to index 0 in the next cycle.

// File: rtl/pix_seq_pkg.sv
package pix_seq_pkg;

    parameter int unsigned PIX_DEFAULT = 128;

    // Flag pair held by the index tracker.
    typedef struct packed {
        logic valid;
        logic err;
    } trk_flags_t;

endpackage

// File: rtl/token_chain.sv
module token_chain #(
    parameter int unsigned NPIX = pix_seq_pkg::PIX_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inject_i,
    output logic [NPIX-1:0] tok_o,
    output logic            tail_o
);

    typedef struct packed {
        logic [NPIX-1:0] tok;
        logic            tail;
    } chain_t;

    chain_t          st_d, st_q;
    logic [NPIX-1:0] feed;

    // Each stage takes the token from the stage below; stage 0 from inject.
    assign feed[0] = inject_i;
    for (genvar g = 1; g < NPIX; g++) begin : g_stage
        assign feed[g] = st_q.tok[g-1];
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.tok  = feed;
            st_d.tail = st_q.tok[NPIX-1];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tok_o  = st_q.tok;
    assign tail_o = st_q.tail;

endmodule

// File: rtl/idx_tracker.sv
module idx_tracker #(
    parameter int unsigned NPIX  = pix_seq_pkg::PIX_DEFAULT,
    parameter int unsigned IDX_W = $clog2(NPIX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             accept_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o,
    output logic             err_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

    typedef struct packed {
        logic [IDX_W-1:0]         idx;
        pix_seq_pkg::trk_flags_t  f;
    } trk_t;

    trk_t st_d, st_q;
    logic accept;

    assign accept = start_i & ~st_q.f.valid;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            if (start_i && st_q.f.valid) begin
                st_d.f.err = 1'b1;
            end
            if (accept) begin
                st_d.idx     = '0;
                st_d.f.valid = 1'b1;
            end else if (st_q.f.valid) begin
                if (st_q.idx == LAST) begin
                    st_d.idx     = '0;
                    st_d.f.valid = 1'b0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign accept_o = accept;
    assign idx_o    = st_q.idx;
    assign valid_o  = st_q.f.valid;
    assign err_o    = st_q.f.err;

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
    parameter int unsigned NPIX = pix_seq_pkg::PIX_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIX-1:0] sel_i,
    output logic [NPIX-1:0] strobe_o,
    output logic            oe_o
);

    typedef struct packed {
        logic [NPIX-1:0] strobe;
    } strb_t;

    strb_t st_d, st_q;

    // The pixel read in this cycle gets its integrator reset in the next one.
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.strobe = sel_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign strobe_o = st_q.strobe;
    assign oe_o     = |sel_i;

endmodule

// File: rtl/pix_token_seq.sv
module pix_token_seq #(
    parameter int unsigned NPIX = pix_seq_pkg::PIX_DEFAULT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    output logic [NPIX-1:0]         sel_onehot_o,
    output logic [$clog2(NPIX)-1:0] sel_idx_o,
    output logic                    sel_valid_o,
    output logic [NPIX-1:0]         rst_strobe_o,
    output logic                    out_en_o,
    output logic                    end_o,
    output logic                    err_o
);

    localparam int unsigned IDX_W = $clog2(NPIX);

    logic            accept;
    logic [NPIX-1:0] tok;

    idx_tracker #(.NPIX(NPIX), .IDX_W(IDX_W)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .accept_o (accept),
        .idx_o    (sel_idx_o),
        .valid_o  (sel_valid_o),
        .err_o    (err_o)
    );

    token_chain #(.NPIX(NPIX)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .inject_i (accept),
        .tok_o    (tok),
        .tail_o   (end_o)
    );

    strobe_gen #(.NPIX(NPIX)) u_strb (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (tok),
        .strobe_o (rst_strobe_o),
        .oe_o     (out_en_o)
    );

    assign sel_onehot_o = tok;

endmodule

// File: rtl/pix_token_seq_chk.sv
module pix_token_seq_chk #(
    parameter int unsigned NPIX = pix_seq_pkg::PIX_DEFAULT
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start_i,
    input logic [NPIX-1:0]         sel_onehot_o,
    input logic [$clog2(NPIX)-1:0] sel_idx_o,
    input logic                    sel_valid_o,
    input logic [NPIX-1:0]         rst_strobe_o,
    input logic                    out_en_o,
    input logic                    end_o,
    input logic                    err_o
);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (sel_onehot_o == '0 && !sel_valid_o && !end_o && !err_o && rst_strobe_o == '0));

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !sel_valid_o) |=> (sel_valid_o && sel_idx_o == '0));

    p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_onehot_o));

    p_idx_match_r3: assert property (@(posedge clk) disable iff (rst)
        sel_valid_o |-> sel_onehot_o[sel_idx_o]);

    p_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        sel_valid_o |=> (rst_strobe_o[$past(sel_idx_o)] && $countones(rst_strobe_o) == 1));

    p_oe_window_r5: assert property (@(posedge clk) disable iff (rst)
        out_en_o == sel_valid_o);

    p_end_single_r6: assert property (@(posedge clk) disable iff (rst)
        end_o |=> !end_o);

    p_end_idle_r6: assert property (@(posedge clk) disable iff (rst)
        end_o |-> !$past(start_i) || sel_idx_o == '0);

    p_err_set_r7: assert property (@(posedge clk) disable iff (rst)
        (start_i && sel_valid_o) |=> err_o);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

endmodule

bind pix_token_seq pix_token_seq_chk #(.NPIX(NPIX)) u_chk (.*);

// File: tb/pix_token_seq_tb.sv
module pix_token_seq_tb;

    localparam int NPIX   = 128;
    localparam int IDX_W  = 7;
    localparam int PERIOD = 10;
    localparam int WD_CYC = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;

    logic [NPIX-1:0]  sel_onehot, rst_strobe, sel_onehot2, rst_strobe2;
    logic [IDX_W-1:0] sel_idx, sel_idx2;
    logic sel_valid, out_en, end_o, err_o;
    logic sel_valid2, out_en2, end2, err2;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(PERIOD/2) clk = ~clk;

    pix_token_seq #(.NPIX(NPIX)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .sel_onehot_o(sel_onehot), .sel_idx_o(sel_idx), .sel_valid_o(sel_valid),
        .rst_strobe_o(rst_strobe), .out_en_o(out_en), .end_o(end_o), .err_o(err_o)
    );

    // Second section chained from the first one's end token (R9).
    pix_token_seq #(.NPIX(NPIX)) u_dut2 (
        .clk(clk), .rst(rst), .start_i(end_o),
        .sel_onehot_o(sel_onehot2), .sel_idx_o(sel_idx2), .sel_valid_o(sel_valid2),
        .rst_strobe_o(rst_strobe2), .out_en_o(out_en2), .end_o(end2), .err_o(err2)
    );

    typedef struct {
        int pos;
        bit endp;
        int rpix;
        bit err;
        bit inrst;
    } exp_t;

    exp_t q[$];
    int   m_pos = -1;
    bit   m_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver side: behavioural model pushes the expected result of each edge.
    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            m_pos = -1;
            m_err = 0;
            e = '{pos: -1, endp: 0, rpix: -1, err: 0, inrst: 1};
        end else begin
            e.inrst = 0;
            e.rpix  = m_pos;
            e.endp  = (m_pos == NPIX - 1);
            if (m_pos >= 0) begin
                if (start_i) m_err = 1;
                m_pos = (m_pos == NPIX - 1) ? -1 : m_pos + 1;
            end else if (start_i) begin
                m_pos = 0;
            end
            e.pos = m_pos;
            e.err = m_err;
        end
        q.push_back(e);
    end

    // Monitor: pop and compare away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [NPIX-1:0] ev, es;
            string ts;
            e  = q.pop_front();
            ev = (e.pos  >= 0) ? (NPIX'(1) << e.pos)  : '0;
            es = (e.rpix >= 0) ? (NPIX'(1) << e.rpix) : '0;
            ts = e.inrst ? "R1" : (e.pos == 0 ? "R2" : "R3");
            chk(sel_valid == (e.pos >= 0), ts, "sel_valid", sel_valid, e.pos >= 0);
            if (e.pos >= 0) chk(sel_idx == e.pos[IDX_W-1:0], ts, "sel_idx", sel_idx, e.pos);
            chk(sel_onehot == ev, ts, "onehot_bits", $countones(sel_onehot), $countones(ev));
            chk(rst_strobe == es, e.inrst ? "R1" : "R4", "strobe_bits",
                $countones(rst_strobe), $countones(es));
            chk(out_en == (e.pos >= 0), e.inrst ? "R1" : "R5", "out_en", out_en, e.pos >= 0);
            chk(end_o == e.endp, e.inrst ? "R1" : "R6", "end_o", end_o, e.endp);
            chk(err_o == e.err, e.inrst ? "R1" : "R7", "err_o", err_o, e.err);
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Full frame and chaining into the second section.
        pulse_start();
        for (int i = 0; i < 200 && !end_o; i++) @(negedge clk);
        chk(sel_valid2 == 1'b0, "R9", "sec2_valid_before", sel_valid2, 0);
        @(negedge clk);
        chk(sel_valid2 == 1'b1 && sel_idx2 == '0, "R9", "sec2_pixel0", sel_idx2, 0);
        repeat (5) @(negedge clk);

        // Overlapping start: ignored and flagged.
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        repeat (140) @(negedge clk);

        // Mid-frame reset clears everything.
        pulse_start();
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        repeat (3) @(negedge clk);

        // Start on the end cycle and one cycle earlier.
        pulse_start();
        repeat (127) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        chk(end_o == 1'b1, "R6", "end_cycle", end_o, 1);
        @(negedge clk) start_i = 1'b0;
        chk(sel_valid && sel_idx == '0, "R8", "restart_pixel0", sel_idx, 0);
        repeat (135) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_CYC, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule